// File: doc/BRIEF.md
# Register-Extension Prefix Classifier

This block looks at the first bytes of a variable-length instruction and says whether they start with a register-extension prefix. It handles four cases: a one-byte extension prefix, a two-byte extension prefix, a vector-extension escape, or no prefix at all (a plain opcode). It also reports the operand-width bit, the opcode-map select bit and the byte offset at which the opcode sits. The extension bits are merged with the ModR/M and SIB register fields to build 5-bit register numbers, so 32 general registers can be named.

An instruction fetch stage gives it a byte window and a mode flag that says whether the core runs in 64-bit mode or in legacy mode. The result is registered and appears one clock after the window is accepted. Opcode semantics, immediate and displacement length, and the vector payload beyond its first byte are left to later stages. The byte after the ModR/M position is always decoded as a SIB byte; deciding whether a SIB byte is actually present is the job of the consumer.

Top module: `pfx_decode_top`

## Requirements
- R1: Results are registered. `valid_o` is high exactly one clock after a cycle with `valid_i` high. While `valid_o` is low, `kind_o` reads 0 (none), and it reads 0 after reset. Kind codes: 0 none, 1 plain opcode, 2 one-byte extension, 3 two-byte extension, 4 vector escape.
- R2: In 64-bit mode, a byte 0 of 40h to 4Fh gives kind 2 and opcode offset 1. `wide_o` is byte 0 bit 3 and `map_o` is 0. The ModR/M byte is taken at byte 2 and the SIB byte at byte 3.
- R3: For kind 2, bits 2, 1 and 0 of byte 0 become bit 3 of the reg, index and rm/base numbers respectively. Bit 4 of every number is 0. The low three bits come from ModR/M [5:3] and [2:0] and from SIB [5:3] and [2:0].
- R4: In 64-bit mode, a byte 0 of D5h gives kind 3 and opcode offset 2. The payload is byte 1: `map_o` is payload bit 7 (0 selects the primary map, 1 the 0F map) and `wide_o` is payload bit 3. The ModR/M byte is taken at byte 3 and the SIB byte at byte 4.
- R5: For kind 3, the reg number is {payload bit 6, bit 2, ModR/M[5:3]}. The index number is {bit 5, bit 1, SIB[5:3]}. The rm number is {bit 4, bit 0, ModR/M[2:0]} and the base number is {bit 4, bit 0, SIB[2:0]}.
- R6: In legacy mode, bytes 40h to 4Fh and D5h are plain opcodes. They give kind 1, offset 0, `wide_o` 0, `map_o` 0, and register bits [4:3] equal to 0.
- R7: In legacy mode, 62h followed by a byte whose bits [7:6] are not 11b is a plain opcode (kind 1, offset 0), and byte 1 is decoded as its ModR/M.
- R8: Byte 62h gives kind 4 in 64-bit mode whatever byte 1 holds. It also gives kind 4 in legacy mode when byte 1 bits [7:6] are 11b. The opcode offset is then 4, with `wide_o` 0 and `map_o` 0. The inverted bits 7, 6 and 5 of byte 1 become bit 3 of reg, index and rm/base respectively. All other register bits are 0.
- R9: Any other byte 0 gives kind 1 and offset 0, with `wide_o` 0 and `map_o` 0. The ModR/M byte is byte 1 and the SIB byte is byte 2, and register bits [4:3] are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte window is valid this cycle |
| long_mode_i | input | 1 | 1 = 64-bit mode, 0 = legacy mode |
| win_i | input | 40 | Byte window; byte k sits at bits [8k+7:8k] |
| valid_o | output | 1 | Registered result valid |
| kind_o | output | 3 | Prefix kind code |
| wide_o | output | 1 | Operand-width bit |
| map_o | output | 1 | Opcode-map select |
| opc_ofs_o | output | 3 | Byte offset of the opcode |
| reg_o | output | 5 | ModR/M reg register number |
| rm_o | output | 5 | ModR/M rm register number |
| idx_o | output | 5 | SIB index register number |
| base_o | output | 5 | SIB base register number |

## Verification
The assertions watch several properties on every cycle. They check that an extension kind never appears unless 64-bit mode was set, that the offset matches the kind, and that register bit 4 stays clear unless a two-byte prefix was seen. They also check that the valid flag follows its input by one clock and that an idle output reports kind none. Only the bench's scenarios can confirm the actual bit placement: that each payload bit lands in the right operand, and that the inverted vector bits come out un-inverted. The same holds for the MOD-based split of 62h in legacy mode and for the reuse of the B bits for both rm and base. These are checked by comparing against expected results built from the requirements, using directed and random windows in both modes.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int unsigned REG_W = 5;
  localparam int unsigned OFS_W = 3;

  typedef enum logic [2:0] {
    PK_NONE  = 3'd0,
    PK_PLAIN = 3'd1,
    PK_EXT1  = 3'd2,
    PK_EXT2  = 3'd3,
    PK_VEC   = 3'd4
  } pfx_kind_e;

  typedef struct packed {
    logic map;
    logic w;
    logic r4;
    logic x4;
    logic b4;
    logic r3;
    logic x3;
    logic b3;
  } ext_bits_t;
endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
  import pfx_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 5
) (
  input  logic                     long_mode_i,
  input  logic [WIN_BYTES*8-1:0]   win_i,
  output pfx_kind_e                kind_o,
  output logic [OFS_W-1:0]         ofs_o
);
  logic [7:0] b0, b1;
  assign b0 = win_i[7:0];
  assign b1 = win_i[15:8];

  always_comb begin
    kind_o = PK_PLAIN;
    ofs_o  = '0;
    // 62h: vector escape in 64-bit mode, or in legacy mode when MOD==11b
    if (b0 == 8'h62 && (long_mode_i || b1[7:6] == 2'b11)) begin
      kind_o = PK_VEC;
      ofs_o  = OFS_W'(4);
    end else if (long_mode_i && b0[7:4] == 4'h4) begin
      kind_o = PK_EXT1;
      ofs_o  = OFS_W'(1);
    end else if (long_mode_i && b0 == 8'hD5) begin
      kind_o = PK_EXT2;
      ofs_o  = OFS_W'(2);
    end
  end
endmodule

// File: rtl/pfx_ext_bits.sv
module pfx_ext_bits
  import pfx_pkg::*;
(
  input  pfx_kind_e   kind_i,
  input  logic [7:0]  b0_i,
  input  logic [7:0]  b1_i,
  output ext_bits_t   ext_o
);
  always_comb begin
    ext_o = '0;
    unique case (kind_i)
      PK_EXT1: begin
        ext_o.w  = b0_i[3];
        ext_o.r3 = b0_i[2];
        ext_o.x3 = b0_i[1];
        ext_o.b3 = b0_i[0];
      end
      PK_EXT2: begin
        ext_o.map = b1_i[7];
        ext_o.r4  = b1_i[6];
        ext_o.x4  = b1_i[5];
        ext_o.b4  = b1_i[4];
        ext_o.w   = b1_i[3];
        ext_o.r3  = b1_i[2];
        ext_o.x3  = b1_i[1];
        ext_o.b3  = b1_i[0];
      end
      PK_VEC: begin
        // stored inverted in the first payload byte
        ext_o.r3 = ~b1_i[7];
        ext_o.x3 = ~b1_i[6];
        ext_o.b3 = ~b1_i[5];
      end
      default: ext_o = '0;
    endcase
  end
endmodule

// File: rtl/pfx_reg_merge.sv
module pfx_reg_merge
  import pfx_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 5
) (
  input  pfx_kind_e               kind_i,
  input  logic [OFS_W-1:0]        ofs_i,
  input  ext_bits_t               ext_i,
  input  logic [WIN_BYTES*8-1:0]  win_i,
  output logic [REG_W-1:0]        reg_o,
  output logic [REG_W-1:0]        rm_o,
  output logic [REG_W-1:0]        idx_o,
  output logic [REG_W-1:0]        base_o
);
  localparam int unsigned IDX_W = $clog2(WIN_BYTES);

  logic [7:0]       win_b [WIN_BYTES];
  logic [IDX_W-1:0] mrm_at, sib_at;
  logic [7:0]       mrm, sib;
  logic [3:0]       hi, lo;
  logic [REG_W-1:0] fld [4];

  for (genvar k = 0; k < WIN_BYTES; k++) begin : g_bytes
    assign win_b[k] = win_i[8*k +: 8];
  end

  // vector escape puts ModR/M beyond the window; use byte 0 and mask below
  assign mrm_at = (kind_i == PK_VEC) ? '0 : IDX_W'(ofs_i) + IDX_W'(1);
  assign sib_at = (kind_i == PK_VEC) ? '0 : IDX_W'(ofs_i) + IDX_W'(2);
  assign mrm    = win_b[mrm_at];
  assign sib    = win_b[sib_at];

  // operand order: 0 reg, 1 rm, 2 index, 3 base
  assign hi = {ext_i.b4, ext_i.x4, ext_i.b4, ext_i.r4};
  assign lo = {ext_i.b3, ext_i.x3, ext_i.b3, ext_i.r3};

  for (genvar g = 0; g < 4; g++) begin : g_opnd
    localparam bit          FROM_SIB = (g >= 2);
    localparam int unsigned LSB      = (g % 2 == 0) ? 3 : 0;
    logic [2:0] low3;
    assign low3   = FROM_SIB ? sib[LSB +: 3] : mrm[LSB +: 3];
    assign fld[g] = (kind_i == PK_VEC) ? {1'b0, lo[g], 3'b000}
                                       : {hi[g], lo[g], low3};
  end

  assign reg_o  = fld[0];
  assign rm_o   = fld[1];
  assign idx_o  = fld[2];
  assign base_o = fld[3];
endmodule

// File: rtl/pfx_decode_top.sv
module pfx_decode_top
  import pfx_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 5,
  localparam int unsigned WIN_W    = WIN_BYTES * 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               long_mode_i,
  input  logic [WIN_W-1:0]   win_i,
  output logic               valid_o,
  output logic [2:0]         kind_o,
  output logic               wide_o,
  output logic               map_o,
  output logic [OFS_W-1:0]   opc_ofs_o,
  output logic [REG_W-1:0]   reg_o,
  output logic [REG_W-1:0]   rm_o,
  output logic [REG_W-1:0]   idx_o,
  output logic [REG_W-1:0]   base_o
);
  pfx_kind_e        kind_c;
  logic [OFS_W-1:0] ofs_c;
  ext_bits_t        ext_c;
  logic [REG_W-1:0] reg_c, rm_c, idx_c, base_c;

  pfx_classify #(.WIN_BYTES(WIN_BYTES)) u_cls (
    .long_mode_i (long_mode_i),
    .win_i       (win_i),
    .kind_o      (kind_c),
    .ofs_o       (ofs_c)
  );

  pfx_ext_bits u_ext (
    .kind_i (kind_c),
    .b0_i   (win_i[7:0]),
    .b1_i   (win_i[15:8]),
    .ext_o  (ext_c)
  );

  pfx_reg_merge #(.WIN_BYTES(WIN_BYTES)) u_mrg (
    .kind_i (kind_c),
    .ofs_i  (ofs_c),
    .ext_i  (ext_c),
    .win_i  (win_i),
    .reg_o  (reg_c),
    .rm_o   (rm_c),
    .idx_o  (idx_c),
    .base_o (base_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      kind_o    <= PK_NONE;
      wide_o    <= 1'b0;
      map_o     <= 1'b0;
      opc_ofs_o <= '0;
      reg_o     <= '0;
      rm_o      <= '0;
      idx_o     <= '0;
      base_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        kind_o    <= kind_c;
        wide_o    <= ext_c.w;
        map_o     <= ext_c.map;
        opc_ofs_o <= ofs_c;
        reg_o     <= reg_c;
        rm_o      <= rm_c;
        idx_o     <= idx_c;
        base_o    <= base_c;
      end else begin
        kind_o    <= PK_NONE;
        wide_o    <= 1'b0;
        map_o     <= 1'b0;
        opc_ofs_o <= '0;
        reg_o     <= '0;
        rm_o      <= '0;
        idx_o     <= '0;
        base_o    <= '0;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  // R1
  idle_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> kind_o == PK_NONE);

  // R6
  ext_needs_long_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (kind_o == PK_EXT1 || kind_o == PK_EXT2)) |-> $past(long_mode_i));

  // R4
  ext2_marker_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && kind_o == PK_EXT2) |-> $past(win_i[7:0]) == 8'hD5);

  // R2
  ext1_ofs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && kind_o == PK_EXT1) |-> opc_ofs_o == OFS_W'(1));

  // R8
  vec_ofs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && kind_o == PK_VEC) |-> (opc_ofs_o == OFS_W'(4) && !wide_o && !map_o));

  // R3
  hi_bit_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && kind_o != PK_EXT2) |-> !(reg_o[4] || rm_o[4] || idx_o[4] || base_o[4]));

  // R9
  plain_low_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && kind_o == PK_PLAIN) |->
      (reg_o[4:3] == 2'b00 && rm_o[4:3] == 2'b00 && opc_ofs_o == '0 && !map_o));
endmodule

// File: tb/pfx_decode_top_tb_top.sv
module pfx_decode_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        long_mode_i = 1'b0;
  logic [39:0] win_i = '0;
  logic        valid_o, wide_o, map_o;
  logic [2:0]  kind_o, opc_ofs_o;
  logic [4:0]  reg_o, rm_o, idx_o, base_o;

  always #2 clk_i = ~clk_i;

  pfx_decode_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .long_mode_i(long_mode_i),
    .win_i(win_i), .valid_o(valid_o), .kind_o(kind_o), .wide_o(wide_o),
    .map_o(map_o), .opc_ofs_o(opc_ofs_o), .reg_o(reg_o), .rm_o(rm_o),
    .idx_o(idx_o), .base_o(base_o)
  );

  typedef struct {
    logic [2:0] kind;
    logic       w;
    logic       map;
    logic [2:0] ofs;
    logic [4:0] rg, rm, ix, bs;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int   total = 0;
  int   bad = 0;
  int   cyc = 0;
  bit   done = 0;

  // Expected result built from the requirement text
  function automatic exp_t model(input logic lm, input logic [39:0] w);
    exp_t e;
    logic [7:0] b0, b1, mrm, sib;
    logic r4, x4, b4, r3, x3, b3;
    int o;
    b0 = w[7:0]; b1 = w[15:8];
    e.w = 0; e.map = 0; r4 = 0; x4 = 0; b4 = 0; r3 = 0; x3 = 0; b3 = 0;
    if (b0 == 8'h62 && (lm || b1[7:6] == 2'b11)) begin
      e.kind = 3'd4; e.ofs = 3'd4; e.tag = "R8";
      e.rg = {1'b0, ~b1[7], 3'b0};
      e.ix = {1'b0, ~b1[6], 3'b0};
      e.rm = {1'b0, ~b1[5], 3'b0};
      e.bs = {1'b0, ~b1[5], 3'b0};
      return e;
    end
    if (lm && b0[7:4] == 4'h4) begin
      e.kind = 3'd2; e.ofs = 3'd1; e.tag = "R3";
      e.w = b0[3]; r3 = b0[2]; x3 = b0[1]; b3 = b0[0];
    end else if (lm && b0 == 8'hD5) begin
      e.kind = 3'd3; e.ofs = 3'd2; e.tag = "R5";
      e.map = b1[7]; r4 = b1[6]; x4 = b1[5]; b4 = b1[4];
      e.w = b1[3]; r3 = b1[2]; x3 = b1[1]; b3 = b1[0];
    end else begin
      e.kind = 3'd1; e.ofs = 3'd0;
      e.tag = (b0 == 8'h62) ? "R7" : ((b0[7:4] == 4'h4 || b0 == 8'hD5) ? "R6" : "R9");
    end
    o = int'(e.ofs);
    mrm = w[8*(o+1) +: 8];
    sib = w[8*(o+2) +: 8];
    e.rg = {r4, r3, mrm[5:3]};
    e.rm = {b4, b3, mrm[2:0]};
    e.ix = {x4, x3, sib[5:3]};
    e.bs = {b4, b3, sib[2:0]};
    return e;
  endfunction

  task automatic drive(input logic lm, input logic [39:0] w, input string tag);
    exp_t e;
    @(negedge clk_i);
    e = model(lm, w);
    if (tag != "") e.tag = tag;
    sb_q.push_back(e);
    valid_i = 1'b1; long_mode_i = lm; win_i = w;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0; win_i = 40'hFFFF_FFFF_FF;
    end
  endtask

  // Monitor / scoreboard
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && !done) begin
      if (valid_o) begin
        exp_t e;
        total++;
        if (sb_q.size() == 0) begin
          bad++;
          $display("FAIL R1: unexpected valid_o, actual kind=%0d expected none", kind_o);
        end else begin
          e = sb_q.pop_front();
          if (kind_o !== e.kind || wide_o !== e.w || map_o !== e.map ||
              opc_ofs_o !== e.ofs || reg_o !== e.rg || rm_o !== e.rm ||
              idx_o !== e.ix || base_o !== e.bs) begin
            bad++;
            $display("FAIL %s: actual k=%0d w=%b m=%b o=%0d r=%h rm=%h ix=%h bs=%h expected k=%0d w=%b m=%b o=%0d r=%h rm=%h ix=%h bs=%h",
              e.tag, kind_o, wide_o, map_o, opc_ofs_o, reg_o, rm_o, idx_o, base_o,
              e.kind, e.w, e.map, e.ofs, e.rg, e.rm, e.ix, e.bs);
          end
        end
      end else begin
        total++;
        if (kind_o !== 3'd0 || sb_q.size() != 0) begin
          bad++;
          $display("FAIL R1: idle output, actual kind=%0d pending=%0d expected kind=0 pending=0",
                   kind_o, sb_q.size());
        end
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    total++;
    if (valid_o !== 1'b0 || kind_o !== 3'd0) begin
      bad++;
      $display("FAIL R1: reset state actual valid=%b kind=%0d expected 0 0", valid_o, kind_o);
    end
    rst_ni = 1'b1;
    idle(2);

    // R9 plain opcode, legacy
    drive(1'b0, 40'h00_00_24_D8_89, "R9");
    // R2 one-byte prefix, W set, R and B set
    drive(1'b1, 40'h00_5B_C8_89_4D, "R2");
    // R3 one-byte prefix, X only
    drive(1'b1, 40'h00_00_A4_8B_42, "R3");
    // R6 same bytes in legacy mode
    drive(1'b0, 40'h00_5B_C8_89_4D, "R6");
    // R4 two-byte prefix, all payload bits set: map 1
    drive(1'b1, 40'hFF_FF_AF_FF_D5, "R4");
    // R5 two-byte prefix, payload 00h: map 0
    drive(1'b1, 40'h1B_C1_8B_00_D5, "R5");
    // R5 split high/low bits: R4 only and B3 only
    drive(1'b1, 40'h00_3F_01_41_D5, "R5");
    // R6 D5h in legacy mode
    drive(1'b0, 40'h00_00_1C_CA_D5, "R6");
    // R7 62h legacy, MOD=01b
    drive(1'b0, 40'h00_00_2A_71_62, "R7");
    // R8 62h legacy, MOD=11b, inverted bits all ones
    drive(1'b0, 40'h00_00_7C_E2_62, "R8");
    // R8 62h 64-bit, MOD=00b, inverted bits all zero
    drive(1'b1, 40'h00_00_7C_1F_62, "R8");
    // R8 62h 64-bit, only middle bit clear
    drive(1'b1, 40'h00_00_00_A0_62, "R8");
    idle(3);

    // Random sweep in both modes with biased first byte
    for (int i = 0; i < 3000; i++) begin
      logic [39:0] w;
      logic [2:0]  sel;
      w = {$urandom(), 8'($urandom())};
      sel = 3'($urandom());
      case (sel)
        3'd0, 3'd1: w[7:0] = {4'h4, 4'($urandom())};
        3'd2, 3'd3: w[7:0] = 8'hD5;
        3'd4:       w[7:0] = 8'h62;
        default:    ;
      endcase
      drive(1'($urandom()), w, "");
      if (sel == 3'd7) idle(1);
    end
    idle(4);

    done = 1;
    total++;
    if (sb_q.size() != 0) begin
      bad++;
      $display("FAIL R1: actual pending=%0d expected 0", sb_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule